// File: doc/BRIEF.md
# Depth Compare Unit with Pixel Write Mask

The unit takes two 64-bit operands that hold packed depth values, either four 16-bit depths or two 32-bit depths, with lane 0 in the least significant bits. It returns a 64-bit word in which each lane holds the smaller of the two input depths. It also keeps an 8-bit pixel write mask as a running history. Each compare shifts the older bits toward the low end, and the new "source B is not farther than source A" flags enter at the top. Every compare also raises a one-cycle pulse that tells a neighbouring accumulator to clear itself.

The result takes one of two paths. In the direct path the minimum word comes back on the next cycle. In the one-deep pipelined path the output carries the minimum that the previous pipelined compare computed. The current minimum is parked in a holding register, and that register starts at zero after reset.

A store-enable decoder turns the current mask into byte enables for a selective write of one 64-bit word, for 8-, 16- or 32-bit pixels. The decoder is combinational and always reads the mask as it stands before any compare in the same cycle.

A small result-stage state machine tracks what the output holds, using three states:
- ST_IDLE: no new result.
- ST_DIRECT: a direct-path result.
- ST_PIPED: a pipelined-path result.

Its transitions are:
- Any state goes to ST_DIRECT on a compare with `op_piped`=0.
- Any state goes to ST_PIPED on a compare with `op_piped`=1.
- Any state goes to ST_IDLE when there is no compare.

`res_valid` is high in ST_DIRECT and ST_PIPED.

Top module: `zcmp_unit`

## Requirements
- R1: After reset, `mask_q`=0, `res_data`=0, `res_valid`=0 and `merge_clr`=0, and `st_be`=0 whatever the store inputs are.
- R2: For a compare with `op_wide`=0 (16-bit lanes), the next cycle's `mask_q` is the old mask shifted right by 4. Bit 4+i is set when lane i of `src_b` ≤ lane i of `src_a`, compared unsigned.
- R3: For a compare with `op_wide`=1 (32-bit lanes), the next cycle's `mask_q` is the old mask shifted right by 2. Bit 6+j is set when 32-bit lane j of `src_b` ≤ lane j of `src_a`, compared unsigned.
- R4: A compare with `op_piped`=0 puts the lane-wise unsigned minimum of `src_a` and `src_b` on `res_data` on the next cycle, with `res_valid`=1.
- R5: A compare with `op_piped`=1 puts the minimum computed by the previous pipelined compare on `res_data` (zero for the first one after reset), with `res_valid`=1. Direct compares leave the held value untouched.
- R6: `merge_clr` is high for exactly the cycle after each compare, in all four lane/path variants.
- R7: A cycle without `op_valid` leaves `mask_q` unchanged and gives `res_valid`=0 and `merge_clr`=0 on the next cycle.
- R8: With `st_valid`=1 and `st_psize`=0 (8-bit pixels), `st_be[k]` = `mask_q[k]`.
- R9: With `st_valid`=1 and `st_psize`=1 (16-bit pixels), bytes 2k and 2k+1 are enabled by `mask_q[k]`, for k = 0..3.
- R10: With `st_valid`=1 and `st_psize`=2 (32-bit pixels), bytes 4k..4k+3 are enabled by `mask_q[k]`, for k = 0..1.
- R11: `st_be`=0 whenever `st_valid`=0 or `st_psize`=3.
- R12: A store and a compare in the same cycle: `st_be` reflects the mask before that compare, and it shows the updated mask from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start a depth compare this cycle |
| op_wide | input | 1 | 0 = four 16-bit lanes, 1 = two 32-bit lanes |
| op_piped | input | 1 | 0 = direct path, 1 = one-deep pipelined path |
| src_a | input | 64 | Depth operand A |
| src_b | input | 64 | Depth operand B |
| res_valid | output | 1 | A result is on `res_data` |
| res_data | output | 64 | Lane-wise minimum depths |
| mask_q | output | 8 | Pixel write mask history |
| merge_clr | output | 1 | Clear pulse for the merge accumulator |
| st_valid | input | 1 | Selective pixel store requested |
| st_psize | input | 2 | Pixel size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = none |
| st_be | output | 8 | Byte enables for the 64-bit store |

## Verification
A compare and a masked store can fall in the same cycle. The store's byte enables must then come from the mask as it was before the compare, and the updated history must appear only after the clock edge. The bench shows this by setting a known mask, then holding a store request steady while it issues a compare that changes the mask. It judges `st_be` against the old mask before the edge and against the new mask after it. It also repeats the pattern for the pipelined path, where the result lags by one compare while the mask does not.

// File: rtl/zc_pkg.sv
package zc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIRECT = 2'd1,
        ST_PIPED  = 2'd2
    } res_state_e;

    typedef enum logic [1:0] {
        PX_8    = 2'd0,
        PX_16   = 2'd1,
        PX_32   = 2'd2,
        PX_NONE = 2'd3
    } px_size_e;
endpackage

// File: rtl/zc_lanes.sv
module zc_lanes #(
    parameter int WORD_W = 64,
    parameter int LANE_W = 16,
    localparam int LANES = WORD_W / LANE_W
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] min_o,
    output logic [LANES-1:0]  le_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la;
        logic [LANE_W-1:0] lb;
        assign la = a_i[i*LANE_W +: LANE_W];
        assign lb = b_i[i*LANE_W +: LANE_W];
        assign le_o[i] = (lb <= la);
        assign min_o[i*LANE_W +: LANE_W] = (lb <= la) ? lb : la;
    end
endmodule

// File: rtl/zc_mask.sv
module zc_mask #(
    parameter int MASK_W = 8,
    parameter int N16    = 4,
    parameter int N32    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic              wide_i,
    input  logic [N16-1:0]    le16_i,
    input  logic [N32-1:0]    le32_i,
    output logic [MASK_W-1:0] mask_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (upd_i) begin
            if (wide_i) begin
                mask_o <= {le32_i, mask_o[MASK_W-1:N32]};
            end else begin
                mask_o <= {le16_i, mask_o[MASK_W-1:N16]};
            end
        end
    end
endmodule

// File: rtl/zc_store_be.sv
module zc_store_be
    import zc_pkg::*;
#(
    parameter int MASK_W = 8
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic              st_valid_i,
    input  logic [1:0]        psize_i,
    output logic [MASK_W-1:0] be_o
);
    px_size_e psz;
    assign psz = px_size_e'(psize_i);

    for (genvar k = 0; k < MASK_W; k++) begin : g_byte
        always_comb begin
            be_o[k] = 1'b0;
            if (st_valid_i) begin
                unique case (psz)
                    PX_8:    be_o[k] = mask_i[k];
                    PX_16:   be_o[k] = mask_i[k/2];
                    PX_32:   be_o[k] = mask_i[k/4];
                    PX_NONE: be_o[k] = 1'b0;
                    default: be_o[k] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/zcmp_unit.sv
module zcmp_unit
    import zc_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_wide,
    input  logic              op_piped,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_data,
    output logic [WORD_W/8-1:0] mask_q,
    output logic              merge_clr,
    input  logic              st_valid,
    input  logic [1:0]        st_psize,
    output logic [WORD_W/8-1:0] st_be
);
    localparam int MASK_W = WORD_W / 8;
    localparam int N16    = WORD_W / 16;
    localparam int N32    = WORD_W / 32;

    logic [WORD_W-1:0] min16, min32, min_sel;
    logic [N16-1:0]    le16;
    logic [N32-1:0]    le32;
    logic [WORD_W-1:0] hold_q;
    res_state_e        state_q, state_d;

    zc_lanes #(.WORD_W(WORD_W), .LANE_W(16)) u_l16 (
        .a_i(src_a), .b_i(src_b), .min_o(min16), .le_o(le16)
    );
    zc_lanes #(.WORD_W(WORD_W), .LANE_W(32)) u_l32 (
        .a_i(src_a), .b_i(src_b), .min_o(min32), .le_o(le32)
    );
    assign min_sel = op_wide ? min32 : min16;

    zc_mask #(.MASK_W(MASK_W), .N16(N16), .N32(N32)) u_mask (
        .clk(clk), .rst_n(rst_n), .upd_i(op_valid), .wide_i(op_wide),
        .le16_i(le16), .le32_i(le32), .mask_o(mask_q)
    );

    zc_store_be #(.MASK_W(MASK_W)) u_be (
        .mask_i(mask_q), .st_valid_i(st_valid), .psize_i(st_psize), .be_o(st_be)
    );

    // Next-state selection for the result stage
    always_comb begin
        state_d = ST_IDLE;
        unique case ({op_valid, op_piped})
            2'b10:   state_d = ST_DIRECT;
            2'b11:   state_d = ST_PIPED;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state
    always_comb begin
        res_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   res_valid = 1'b0;
            ST_DIRECT: res_valid = 1'b1;
            ST_PIPED:  res_valid = 1'b1;
            default:   res_valid = 1'b0;
        endcase
    end

    // Result datapath and one-deep holding stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data  <= '0;
            hold_q    <= '0;
            merge_clr <= 1'b0;
        end else begin
            merge_clr <= op_valid;
            if (op_valid) begin
                if (op_piped) begin
                    res_data <= hold_q;
                    hold_q   <= min_sel;
                end else begin
                    res_data <= min_sel;
                end
            end
        end
    end
endmodule

// File: rtl/zcmp_unit_chk.sv
module zcmp_unit_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_wide,
    input logic              op_piped,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic              res_valid,
    input logic [WORD_W-1:0] res_data,
    input logic [WORD_W/8-1:0] mask_q,
    input logic              merge_clr,
    input logic              st_valid,
    input logic [1:0]        st_psize,
    input logic [WORD_W/8-1:0] st_be
);
    p_mask_shift16_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_wide |=> mask_q[3:0] == $past(mask_q[7:4]));

    p_mask_shift32_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_wide |=> mask_q[5:0] == $past(mask_q[7:2]));

    p_min_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_piped && !op_wide |=>
            res_valid && res_data[15:0] <= $past(src_a[15:0])
                      && res_data[15:0] <= $past(src_b[15:0]));

    p_merge_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> merge_clr);

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(mask_q) && !merge_clr && !res_valid);

    p_be32_groups_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_psize == 2'd2 |->
            (st_be[3:0] == 4'h0 || st_be[3:0] == 4'hF));

    p_be_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_valid || st_psize == 2'd3) |-> st_be == '0);
endmodule

bind zcmp_unit zcmp_unit_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/tb_zcmp_unit.sv
module tb_zcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_wide = 1'b0, op_piped = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic [7:0]  mask_q;
    logic        merge_clr;
    logic        st_valid = 1'b0;
    logic [1:0]  st_psize = 2'd0;
    logic [7:0]  st_be;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  m_mask = '0;
    logic [63:0] m_hold = '0;

    always #5 clk = ~clk;

    zcmp_unit dut (.*);

    // {wide, piped, a, b}
    localparam logic [129:0] VEC [8] = '{
        {1'b0, 1'b0, 64'h0001_8000_FFFF_0000, 64'h0001_7FFF_0000_FFFF},
        {1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_0000_FFFF_DEF1},
        {1'b0, 1'b1, 64'h0000_0000_0000_0000, 64'hFFFF_0000_0001_0000},
        {1'b1, 1'b0, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0001},
        {1'b1, 1'b1, 64'h0000_0010_FFFF_FFFF, 64'h0000_0011_FFFF_FFFE},
        {1'b0, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555},
        {1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_min(input logic w, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        if (w) begin
            for (int j = 0; j < 2; j++)
                r[j*32 +: 32] = (b[j*32 +: 32] < a[j*32 +: 32]) ? b[j*32 +: 32] : a[j*32 +: 32];
        end else begin
            for (int i = 0; i < 4; i++)
                r[i*16 +: 16] = (b[i*16 +: 16] < a[i*16 +: 16]) ? b[i*16 +: 16] : a[i*16 +: 16];
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_mask(input logic w, input logic [7:0] m,
                                            input logic [63:0] a, input logic [63:0] b);
        logic [7:0] r;
        if (w) begin
            r = m >> 2;
            for (int j = 0; j < 2; j++) r[6+j] = (b[j*32 +: 32] <= a[j*32 +: 32]);
        end else begin
            r = m >> 4;
            for (int i = 0; i < 4; i++) r[4+i] = (b[i*16 +: 16] <= a[i*16 +: 16]);
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_be(input logic [7:0] m, input logic [1:0] ps);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            case (ps)
                2'd0: r[k] = m[k];
                2'd1: r[k] = m[k/2];
                2'd2: r[k] = m[k/4];
                default: r[k] = 1'b0;
            endcase
        end
        return r;
    endfunction

    // Issue one compare, update the model and check the outputs of the following cycle
    task automatic do_op(input logic w, input logic p, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp_res;
        @(negedge clk);
        op_valid = 1'b1; op_wide = w; op_piped = p; src_a = a; src_b = b;
        exp_res = p ? m_hold : ref_min(w, a, b);
        if (p) m_hold = ref_min(w, a, b);
        m_mask = ref_mask(w, m_mask, a, b);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk(p ? "R5 piped result" : "R4 direct result", res_data, exp_res);
        chk(p ? "R5 valid" : "R4 valid", {63'd0, res_valid}, 64'd1);
        chk(w ? "R3 mask" : "R2 mask", {56'd0, mask_q}, {56'd0, m_mask});
        chk("R6 merge_clr", {63'd0, merge_clr}, 64'd1);
    endtask

    task automatic chk_be_all();
        st_valid = 1'b1;
        st_psize = 2'd0; #1; chk("R8 be8",  {56'd0, st_be}, {56'd0, ref_be(m_mask, 2'd0)});
        st_psize = 2'd1; #1; chk("R9 be16", {56'd0, st_be}, {56'd0, ref_be(m_mask, 2'd1)});
        st_psize = 2'd2; #1; chk("R10 be32", {56'd0, st_be}, {56'd0, ref_be(m_mask, 2'd2)});
        st_psize = 2'd3; #1; chk("R11 none", {56'd0, st_be}, 64'd0);
        st_valid = 1'b0; st_psize = 2'd0; #1;
        chk("R11 idle", {56'd0, st_be}, 64'd0);
    endtask

    task automatic run_all();
        logic [7:0] old_m;
        // R1 reset state
        #1;
        chk("R1 mask", {56'd0, mask_q}, 64'd0);
        chk("R1 res_data", res_data, 64'd0);
        chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
        chk("R1 merge_clr", {63'd0, merge_clr}, 64'd0);
        st_valid = 1'b1; st_psize = 2'd0; #1;
        chk("R1 st_be", {56'd0, st_be}, 64'd0);
        st_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            do_op(VEC[v][129], VEC[v][128], VEC[v][127:64], VEC[v][63:0]);
            chk_be_all();
        end

        // R7 idle cycles hold the mask and drop valid/clear
        old_m = mask_q;
        repeat (3) @(negedge clk);
        #1;
        chk("R7 mask hold", {56'd0, mask_q}, {56'd0, old_m});
        chk("R7 no valid", {63'd0, res_valid}, 64'd0);
        chk("R7 no clear", {63'd0, merge_clr}, 64'd0);

        // R12 store and compare in the same cycle, both paths
        for (int p = 0; p < 2; p++) begin
            do_op(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
            do_op(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
            old_m = m_mask;
            @(negedge clk);
            st_valid = 1'b1; st_psize = 2'd0;
            op_valid = 1'b1; op_wide = 1'b1; op_piped = p[0];
            src_a = 64'd0; src_b = 64'h0000_0001_0000_0001;
            #1;
            chk("R12 before edge", {56'd0, st_be}, {56'd0, old_m});
            m_mask = ref_mask(1'b1, m_mask, src_a, src_b);
            if (p[0]) m_hold = ref_min(1'b1, src_a, src_b);
            @(negedge clk);
            op_valid = 1'b0;
            #1;
            chk("R12 after edge", {56'd0, st_be}, {56'd0, m_mask});
            st_valid = 1'b0;
        end

        // R5 direct ops leave the held value alone
        do_op(1'b0, 1'b0, 64'h1111_2222_3333_4444, 64'h0000_0000_0000_0000);
        do_op(1'b0, 1'b1, 64'h0, 64'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule